// File: doc/BRIEF.md
# Recirculating Serial Bit Loop Memory

This block stores a fixed number of bits in a closed loop. Each shift pulse moves every stored bit one place along the loop. The bit that leaves the far end is written back into the near end, so the contents keep circulating and nothing is lost. Only one position of the loop can be seen at any moment: the one at the exit. A rotation counter that wraps at the loop length records which logical bit index is sitting there.

A client asks for a single bit by index, either to fetch it or to overwrite it. The request is held until the chosen index reaches the exit. A fetch then returns the bit with a one-cycle valid strobe. A store puts the new bit in place of the recirculated one. The wait depends on where the loop stands when the request is taken, from one shift up to a full turn. Only one request is held at a time. `busy` shows that a request is outstanding, and any request made while it is high is dropped.

Top module: `ring_serial_mem`

## Requirements
- R1: After reset, `busy` and `rd_valid` are 0 and the rotation position is 0. A read of index i accepted on the first clock after reset completes after ((i-1) mod LEN)+1 shifts.
- R2: A read of index i accepted at a clock edge where the rotation position is r, with `shift_en` high at every edge, raises `rd_valid` after edge k = ((i-r-1) mod LEN)+1 counted from the accepting edge. `rd_data` then holds the bit stored at index i. Each shift advances the position by one, and it wraps from LEN-1 to 0.
- R3: Stored bits survive any number of full rotations unchanged.
- R4: A write of bit b to index i completes after the same number of shifts as a read would. From then on, index i holds b and every other index is unchanged.
- R5: When `shift_en` is low at an edge, the rotation does not advance, no request completes and no stored bit changes. A pending request is delayed by one shift for each such edge.
- R6: A request is accepted only when `busy` is 0. `busy` is 1 from the accepting edge until the completing edge. Requests made while `busy` is 1 have no effect.
- R7: If `rd_req` and `wr_req` are both high on an idle edge, only the read is taken and the write is dropped.
- R8: A request whose index is LEN or above is refused: `busy` stays 0 and nothing is stored.
- R9: `rd_valid` is a single-cycle pulse that follows only completed reads. A write produces no pulse.
- R10: Reset clears only the control state. The stored bits keep their values through a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Rotate the loop by one position at this edge |
| rd_req | input | 1 | Read request |
| rd_idx | input | IDX_W | Bit index to read |
| wr_req | input | 1 | Write request |
| wr_idx | input | IDX_W | Bit index to write |
| wr_bit | input | 1 | Bit value to write |
| rd_data | output | 1 | Returned bit, valid with `rd_valid` |
| rd_valid | output | 1 | One-cycle strobe marking a completed read |
| busy | output | 1 | A request is outstanding |

## Verification
If the rotation counter or the held index is wrong, the strobe arrives on the wrong edge. Every read is therefore timed against a latency the bench works out from its own count of shifts, and a single missing or extra step shows up as a one-cycle error. A bad recirculation path or a stray write enable corrupts a stored bit. Sweeps that read all indices after several full turns expose this within one rotation. A request that should have been refused shows up at the next idle read of the index it targeted.

// File: rtl/ring_mem_pkg.sv
package ring_mem_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } ring_op_e;

  typedef struct packed {
    logic     valid;
    ring_op_e op;
    logic     data;
  } ring_req_s;
endpackage

// File: rtl/ring_rot_counter.sv
module ring_rot_counter #(
  parameter int LEN   = 50,
  parameter int IDX_W = $clog2(LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  output logic [IDX_W-1:0] rot
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rot <= '0;
    end else if (shift_en) begin
      if (rot == LAST) rot <= '0;
      else             rot <= rot + 1'b1;
    end
  end

  assert_rot_range_R2: assert property (@(posedge clk) disable iff (rst)
    rot <= LAST);
  assert_rot_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(rot));
  assert_rot_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (shift_en && rot == LAST) |=> rot == '0);
endmodule

// File: rtl/ring_req_tracker.sv
module ring_req_tracker
  import ring_mem_pkg::*;
#(
  parameter int LEN   = 50,
  parameter int IDX_W = $clog2(LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic [IDX_W-1:0] rot,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_req,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  output logic             busy,
  output logic             hit_rd,
  output logic             hit_wr,
  output logic             hit_bit
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LEN - 1);

  ring_req_s        held;
  logic [IDX_W-1:0] held_idx;
  logic             take_rd, take_wr, hit;

  // read wins when both are raised; an out-of-range index is refused
  assign take_rd = !held.valid && rd_req && (rd_idx <= LAST);
  assign take_wr = !held.valid && !rd_req && wr_req && (wr_idx <= LAST);
  assign hit     = held.valid && shift_en && (rot == held_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= '{valid: 1'b0, op: OP_READ, data: 1'b0};
      held_idx <= '0;
    end else if (take_rd) begin
      held     <= '{valid: 1'b1, op: OP_READ, data: 1'b0};
      held_idx <= rd_idx;
    end else if (take_wr) begin
      held     <= '{valid: 1'b1, op: OP_WRITE, data: wr_bit};
      held_idx <= wr_idx;
    end else if (hit) begin
      held.valid <= 1'b0;
    end
  end

  assign busy    = held.valid;
  assign hit_rd  = hit && (held.op == OP_READ);
  assign hit_wr  = hit && (held.op == OP_WRITE);
  assign hit_bit = held.data;

  assert_refuse_when_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (held.valid && !(shift_en && rot == held_idx)) |=> (held.valid && $stable(held_idx)));
  assert_range_refused_R8: assert property (@(posedge clk) disable iff (rst)
    (!held.valid && rd_req && rd_idx > LAST) |=> !held.valid);
  assert_read_priority_R7: assert property (@(posedge clk) disable iff (rst)
    (!held.valid && rd_req && wr_req && rd_idx <= LAST) |=> (held.valid && held.op == OP_READ));
  assert_one_hit_R6: assert property (@(posedge clk) disable iff (rst)
    !(hit_rd && hit_wr));
endmodule

// File: rtl/ring_store.sv
module ring_store #(
  parameter int LEN   = 50,
  parameter int IDX_W = $clog2(LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic [IDX_W-1:0] rot,
  input  logic             hit_rd,
  input  logic             hit_wr,
  input  logic             hit_bit,
  output logic             rd_data,
  output logic             rd_valid
);
  // slot p holds logical index p; the rotation counter selects the exit slot
  logic mem [0:LEN-1];
  logic exit_bit, feed_bit;

  assign exit_bit = mem[rot];
  assign feed_bit = hit_wr ? hit_bit : exit_bit;

  // no reset on the array: contents survive reset, RAM-style inference
  always_ff @(posedge clk) begin
    if (shift_en) mem[rot] <= feed_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 1'b0;
    end else begin
      rd_valid <= hit_rd;
      if (hit_rd) rd_data <= exit_bit;
    end
  end

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  assert_valid_needs_shift_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(shift_en));
  assert_data_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> (rd_valid || $stable(rd_data)));
endmodule

// File: rtl/ring_serial_mem.sv
module ring_serial_mem #(
  parameter int LEN   = 50,
  parameter int IDX_W = $clog2(LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_req,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  output logic             rd_data,
  output logic             rd_valid,
  output logic             busy
);
  logic [IDX_W-1:0] rot;
  logic             hit_rd, hit_wr, hit_bit;

  ring_rot_counter #(.LEN(LEN), .IDX_W(IDX_W)) rot_i (
    .clk(clk), .rst(rst), .shift_en(shift_en), .rot(rot)
  );

  ring_req_tracker #(.LEN(LEN), .IDX_W(IDX_W)) req_i (
    .clk(clk), .rst(rst), .shift_en(shift_en), .rot(rot),
    .rd_req(rd_req), .rd_idx(rd_idx), .wr_req(wr_req), .wr_idx(wr_idx),
    .wr_bit(wr_bit), .busy(busy), .hit_rd(hit_rd), .hit_wr(hit_wr),
    .hit_bit(hit_bit)
  );

  ring_store #(.LEN(LEN), .IDX_W(IDX_W)) store_i (
    .clk(clk), .rst(rst), .shift_en(shift_en), .rot(rot),
    .hit_rd(hit_rd), .hit_wr(hit_wr), .hit_bit(hit_bit),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assert_valid_clears_busy_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !busy);
  assert_valid_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(busy));
endmodule

// File: tb/ring_serial_mem_tb_top.sv
module ring_serial_mem_tb_top;
  localparam int LEN   = 50;
  localparam int IDX_W = $clog2(LEN);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 1'b1;
  logic rd_req = 1'b0, wr_req = 1'b0, wr_bit = 1'b0;
  logic [IDX_W-1:0] rd_idx = '0, wr_idx = '0;
  logic rd_data, rd_valid, busy;

  int n_tests = 0, n_fail = 0, mrot = 0;
  bit exp_mem [LEN];
  bit finished = 0;

  always #4 clk = ~clk;

  ring_serial_mem #(.LEN(LEN), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .shift_en(shift_en), .rd_req(rd_req), .rd_idx(rd_idx),
    .wr_req(wr_req), .wr_idx(wr_idx), .wr_bit(wr_bit),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
  );

  // bench-side rotation position, counted from shifts
  always @(posedge clk) begin
    if (rst) mrot <= 0;
    else if (shift_en) mrot <= (mrot + 1) % LEN;
  end

  task automatic chk(bit ok, string req, int act, int expv, string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int lat(int idx, int r);
    return ((idx - r - 1 + LEN) % LEN) + 1;
  endfunction

  // called at a negedge; returns at the negedge after the completion check
  task automatic do_read(int idx, int stall, string req);
    int r, n;
    r = mrot;
    rd_req = 1'b1; rd_idx = IDX_W'(idx);
    @(negedge clk);
    rd_req = 1'b0;
    n = 0;
    while (n < 2 * LEN + stall) begin
      shift_en = (n < stall) ? 1'b0 : 1'b1;
      @(negedge clk);
      n++;
      if (rd_valid) break;
    end
    shift_en = 1'b1;
    chk(n == lat(idx, r) + stall, req, n, lat(idx, r) + stall, "read latency");
    chk(rd_data == exp_mem[idx], req, int'(rd_data), int'(exp_mem[idx]), "read data");
    @(negedge clk);
    chk(rd_valid == 1'b0, "R9", int'(rd_valid), 0, "valid is one pulse");
  endtask

  task automatic do_write(int idx, bit b, string req);
    int r, n;
    bit saw_valid;
    r = mrot;
    wr_req = 1'b1; wr_idx = IDX_W'(idx); wr_bit = b;
    @(negedge clk);
    wr_req = 1'b0;
    chk(busy == 1'b1, "R6", int'(busy), 1, "busy after accept");
    n = 0; saw_valid = 0;
    while (busy && n < 2 * LEN) begin
      @(negedge clk);
      n++;
      if (rd_valid) saw_valid = 1;
    end
    chk(n == lat(idx, r), req, n, lat(idx, r), "write latency");
    chk(!saw_valid, "R9", int'(saw_valid), 0, "no strobe for write");
    exp_mem[idx] = b;
  endtask

  function automatic bit pat(int i, int seed);
    return bit'(((i * 7 + seed) % 5) < 2);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0, "R1", int'(busy), 0, "busy after reset");
    chk(rd_valid == 1'b0, "R1", int'(rd_valid), 0, "valid after reset");
    chk(mrot == 0, "R1", mrot, 0, "bench rotation origin");

    // fill with pattern, then read all back (R4, R2)
    for (int i = 0; i < LEN; i++) do_write(i, pat(i, 3), "R4");
    for (int i = 0; i < LEN; i++) do_read((i * 13) % LEN, 0, "R2");

    // second pattern, written in reverse, read across many rotations (R3)
    for (int i = LEN - 1; i >= 0; i--) do_write(i, pat(i, 1), "R4");
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < LEN; i++) do_read(i, 0, "R3");

    // stalled shifting extends latency and keeps contents (R5)
    do_read(17, 5, "R5");
    do_read(0, 9, "R5");
    do_read(LEN - 1, 3, "R5");

    // requests while busy are ignored (R6)
    begin
      int r0;
      bit old;
      old = exp_mem[5];
      r0 = mrot;
      rd_req = 1'b1; rd_idx = IDX_W'((r0 + 30) % LEN);
      @(negedge clk);
      rd_req = 1'b0;
      wr_req = 1'b1; wr_idx = IDX_W'(5); wr_bit = ~old;
      @(negedge clk);
      wr_req = 1'b0;
      chk(busy == 1'b1, "R6", int'(busy), 1, "still busy");
      while (!rd_valid) @(negedge clk);
      @(negedge clk);
      do_read(5, 0, "R6");
    end

    // simultaneous read and write: read taken (R7)
    begin
      int r0;
      bit old;
      old = exp_mem[22];
      r0 = mrot;
      rd_req = 1'b1; rd_idx = IDX_W'(22);
      wr_req = 1'b1; wr_idx = IDX_W'(22); wr_bit = ~old;
      @(negedge clk);
      rd_req = 1'b0; wr_req = 1'b0;
      begin
        int n;
        n = 0;
        while (!rd_valid && n < 2 * LEN) begin @(negedge clk); n++; end
        chk(n == lat(22, r0), "R7", n, lat(22, r0), "read latency when both raised");
        chk(rd_data == old, "R7", int'(rd_data), int'(old), "read data when both raised");
      end
      @(negedge clk);
      do_read(22, 0, "R7");
    end

    // out-of-range indices refused (R8)
    rd_req = 1'b1; rd_idx = IDX_W'(LEN);
    @(negedge clk);
    rd_req = 1'b0;
    chk(busy == 1'b0, "R8", int'(busy), 0, "read index LEN refused");
    wr_req = 1'b1; wr_idx = '1; wr_bit = 1'b1;
    @(negedge clk);
    wr_req = 1'b0;
    chk(busy == 1'b0, "R8", int'(busy), 0, "write index max refused");
    repeat (LEN + 2) begin
      @(negedge clk);
      if (rd_valid) chk(0, "R8", 1, 0, "stray strobe after refusal");
    end
    for (int i = 0; i < LEN; i++) do_read(i, 0, "R8");

    // contents survive reset; rotation restarts at zero (R10, R1)
    do_write(9, ~exp_mem[9], "R4");
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0, "R1", int'(busy), 0, "busy after second reset");
    do_read(1, 0, "R1");
    do_read(9, 0, "R10");
    for (int i = 0; i < LEN; i++) do_read(i, 0, "R10");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule